// File: doc/BRIEF.md
# Rectified Sliding-Window Averager

This block turns a stream of wide signed samples into a slowly varying level estimate. For each accepted sample it takes the absolute value and drops the low-order bits with a fixed right shift. It then returns the mean of the most recent 1024 such values. A typical use is to follow a filter output and report how much energy is passing through it.

The window mean is kept recursively. Each accepted sample adds its own scaled value to a running total and removes the scaled value that entered exactly one window length earlier. The removed values come from a ring of stored history held in a single inferred RAM. The published result is the running total shifted right by the window exponent. Positions in the window that have not yet been written since reset count as zero, so the first results ramp up from zero.

Top module: `magnitude_average`

## Requirements
- R1: While reset is held and afterwards, until the first result is issued, `avg` is 0 and `avg_valid` is low.
- R2: An accepted sample contributes floor(|in_sample| / 2^20) to the window. The absolute value is taken on the two's-complement 44-bit value.
- R3: When floor(|in_sample| / 2^20) exceeds 262143 (2^18 - 1), the contribution is clamped to 262143. This includes the most negative input.
- R4: A sample is accepted only in a cycle where `in_valid` is high. In other cycles `in_sample` has no effect on any later result, and no result is produced.
- R5: Each accepted sample produces exactly one `avg_valid` pulse, two clock edges after the edge that accepted it. Samples may be accepted on consecutive cycles.
- R6: The result for a sample equals floor(S / 1024). S is the sum of the contributions of that sample and the 1023 accepted samples before it. Samples not yet received since reset count as 0.
- R7: The 1025th accepted sample after reset removes the contribution of the first one, and each later sample likewise removes the one accepted 1024 samples earlier.
- R8: When floor(S / 1024) exceeds 65535, `avg` reads 65535.
- R9: `avg` keeps its value in every cycle in which `avg_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_sample` as a new sample this cycle |
| in_sample | input | 44 | Signed two's-complement sample |
| avg_valid | output | 1 | One-cycle strobe marking a fresh `avg` |
| avg | output | 16 | Window mean of scaled magnitudes |

## Verification
The bench aims at the first window wrap, where a design that gets the history bookkeeping wrong either subtracts stale RAM contents before the window fills or fails to evict the oldest value once it has filled. It drives the most negative input and full-scale positive inputs. A missing clamp would let values of up to 2^23 into the total, and a naive negation would yield a negative magnitude. It holds the input at full scale long enough to push the quotient beyond 16 bits, which exposes output wraparound. It also idles with random data on the bus, which catches a design that samples without qualification or moves its output between results.

// File: rtl/magavg_pkg.sv
package magavg_pkg;
    // Default configuration of the averager
    localparam int unsigned SAMPLE_W   = 44;
    localparam int unsigned MAG_SHIFT  = 20;
    localparam int unsigned LEVEL_W    = 18;
    localparam int unsigned WIN_LOG2   = 10;
    localparam int unsigned RESULT_W   = 16;

    // History ring occupancy
    typedef enum logic {
        HS_FILLING = 1'b0,
        HS_FULL    = 1'b1
    } hist_state_e;
endpackage

// File: rtl/mag_scale.sv
module mag_scale #(
    parameter int unsigned IN_W  = magavg_pkg::SAMPLE_W,
    parameter int unsigned SHIFT = magavg_pkg::MAG_SHIFT,
    parameter int unsigned OUT_W = magavg_pkg::LEVEL_W
) (
    input  logic signed [IN_W-1:0] x,
    output logic [OUT_W-1:0]       y
);
    localparam int unsigned SH_W = IN_W - SHIFT;

    logic [IN_W-1:0] ux;
    logic [IN_W-1:0] mag;
    logic [SH_W-1:0] sh;

    always_comb begin
        ux  = x;
        // unsigned negation keeps 2^(IN_W-1) exact for the most negative input
        mag = ux[IN_W-1] ? (~ux + IN_W'(1)) : ux;
        sh  = mag[IN_W-1:SHIFT];
    end

    generate
        if (SH_W > OUT_W) begin : g_clamp
            always_comb y = (|sh[SH_W-1:OUT_W]) ? '1 : sh[OUT_W-1:0];
        end else begin : g_pass
            always_comb y = OUT_W'(sh);
        end
    endgenerate
endmodule

// File: rtl/hist_ring.sv
module hist_ring #(
    parameter int unsigned DW = magavg_pkg::LEVEL_W,
    parameter int unsigned AW = magavg_pkg::WIN_LOG2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] old_data,
    output logic          old_ok
);
    import magavg_pkg::*;

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] ptr_q;
    hist_state_e   state_q;

    // read-before-write at the same slot: the entry leaving the window
    always_ff @(posedge clk) begin
        if (wr_en) begin
            old_data   <= mem[ptr_q];
            mem[ptr_q] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            state_q <= HS_FILLING;
            old_ok  <= 1'b0;
        end else if (wr_en) begin
            ptr_q  <= ptr_q + AW'(1);
            old_ok <= (state_q == HS_FULL);
            if (ptr_q == {AW{1'b1}})
                state_q <= HS_FULL;
        end
    end
endmodule

// File: rtl/avg_accum.sv
module avg_accum #(
    parameter int unsigned DW    = magavg_pkg::LEVEL_W,
    parameter int unsigned AW    = magavg_pkg::WIN_LOG2,
    parameter int unsigned OUT_W = magavg_pkg::RESULT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [DW-1:0]    add_v,
    input  logic [DW-1:0]    sub_v,
    output logic             res_valid,
    output logic [OUT_W-1:0] res
);
    // a full window of maximum values fits exactly
    localparam int unsigned ACC_W = DW + AW;

    logic [ACC_W-1:0] sum_q;
    logic [DW-1:0]    quot;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= upd;
            if (upd)
                sum_q <= sum_q + ACC_W'(add_v) - ACC_W'(sub_v);
        end
    end

    always_comb quot = sum_q[ACC_W-1:AW];

    generate
        if (DW > OUT_W) begin : g_clamp
            always_comb res = (|quot[DW-1:OUT_W]) ? '1 : quot[OUT_W-1:0];
        end else begin : g_pass
            always_comb res = OUT_W'(quot);
        end
    endgenerate
endmodule

// File: rtl/magnitude_average.sv
module magnitude_average #(
    parameter int unsigned IN_W      = magavg_pkg::SAMPLE_W,
    parameter int unsigned MAG_SHIFT = magavg_pkg::MAG_SHIFT,
    parameter int unsigned LEVEL_W   = magavg_pkg::LEVEL_W,
    parameter int unsigned WIN_LOG2  = magavg_pkg::WIN_LOG2,
    parameter int unsigned OUT_W     = magavg_pkg::RESULT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    output logic                   avg_valid,
    output logic [OUT_W-1:0]       avg
);
    typedef struct packed {
        logic               vld;
        logic [LEVEL_W-1:0] level;
    } stage_t;

    logic [LEVEL_W-1:0] level_now;
    logic [LEVEL_W-1:0] old_level;
    logic               old_ok;
    logic [LEVEL_W-1:0] leaving;
    stage_t             s1_q;

    mag_scale #(.IN_W(IN_W), .SHIFT(MAG_SHIFT), .OUT_W(LEVEL_W)) u_scale (
        .x (in_sample),
        .y (level_now)
    );

    hist_ring #(.DW(LEVEL_W), .AW(WIN_LOG2)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (in_valid),
        .wr_data  (level_now),
        .old_data (old_level),
        .old_ok   (old_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld <= in_valid;
            if (in_valid)
                s1_q.level <= level_now;
        end
    end

    // slots never written since reset count as zero
    always_comb leaving = old_ok ? old_level : '0;

    avg_accum #(.DW(LEVEL_W), .AW(WIN_LOG2), .OUT_W(OUT_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .upd       (s1_q.vld),
        .add_v     (s1_q.level),
        .sub_v     (leaving),
        .res_valid (avg_valid),
        .res       (avg)
    );
endmodule

// File: rtl/magnitude_average_chk.sv
module magnitude_average_chk #(
    parameter int unsigned OUT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             avg_valid,
    input logic [OUT_W-1:0] avg
);
    logic [1:0] since_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else begin
            if (since_q != 2'd3)
                since_q <= since_q + 2'd1;
            if (avg_valid)
                seen_q <= 1'b1;
        end
    end

    // R5: an accepted sample yields a strobe two edges later
    a_r5_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 2'd2 && $past(in_valid, 2)) |-> avg_valid);

    // R4, R5: no strobe without a sample two edges earlier
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 2'd2 && avg_valid) |-> $past(in_valid, 2));

    a_r5_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        (since_q < 2'd2) |-> !avg_valid);

    // R9: output frozen between strobes
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 2'd1 && !avg_valid) |-> $stable(avg));

    // R1: zero until the first result
    a_r1_zero_start: assert property (@(posedge clk) disable iff (rst)
        (!seen_q && !avg_valid) |-> (avg == '0));
endmodule

bind magnitude_average magnitude_average_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .avg_valid (avg_valid),
    .avg       (avg)
);

// File: tb/magnitude_average_tb_top.sv
`timescale 1ns/1ps
module magnitude_average_tb_top;
    localparam int WIN = 1024;
    localparam longint LEVEL_MAX = 262143;
    localparam longint OUT_MAX = 65535;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [43:0] in_sample = '0;
    logic               avg_valid;
    logic [15:0]        avg;

    always #10 clk = ~clk;

    magnitude_average dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .avg_valid (avg_valid),
        .avg       (avg)
    );

    int     checks = 0;
    int     errors = 0;
    bit     done = 1'b0;
    longint hist_m [WIN];
    longint sum_m = 0;
    int     ptr_m = 0;
    longint last_exp = 0;
    longint exp_q [$];
    string  tag_q [$];

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint level_of(longint x);
        longint m;
        m = (x < 0) ? -x : x;
        m = m >> 20;
        if (m > LEVEL_MAX) m = LEVEL_MAX;
        return m;
    endfunction

    // driver: one sample per call, back-to-back when called in a row
    task automatic send(longint x, string tag);
        longint lv;
        longint q;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = x[43:0];
        lv = level_of(x);
        sum_m = sum_m + lv - hist_m[ptr_m];
        hist_m[ptr_m] = lv;
        ptr_m = (ptr_m + 1) % WIN;
        q = sum_m >> 10;
        if (q > OUT_MAX) q = OUT_MAX;
        last_exp = q;
        exp_q.push_back(q);
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_sample = {$urandom, $urandom};
        end
    endtask

    // monitor: compares each strobe against the scoreboard
    always @(negedge clk) begin
        if (!rst && avg_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected strobe", 1, 0);
            end else begin
                longint e;
                string  t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(longint'(avg) == e, t, longint'(avg), e);
            end
        end
    end

    initial begin
        for (int i = 0; i < WIN; i++) hist_m[i] = 0;
        repeat (5) @(negedge clk);
        chk(avg == 16'd0 && !avg_valid, "R1 during reset", longint'(avg), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(avg == 16'd0 && !avg_valid, "R1 after reset", longint'(avg), 0);

        // R2: truncating shift of magnitudes, both signs
        send(longint'(5) <<< 20, "R2 positive");
        send(-((longint'(7) <<< 20) + 12345), "R2 negative");
        send(1000, "R2 below one step");
        // R3: clamp at both extremes
        send((longint'(1) <<< 43) - 1, "R3 full positive");
        send(-(longint'(1) <<< 43), "R3 most negative");
        send(-((longint'(1023) <<< 20) + 5), "R2 mid negative");
        // R4: random bus content while idle
        idle(6);
        chk(longint'(avg) == last_exp, "R4 idle data ignored", longint'(avg), last_exp);
        chk(!avg_valid, "R9 no strobe when idle", longint'(avg_valid), 0);

        // R6: random mix with occasional gaps
        for (int i = 0; i < 300; i++) begin
            longint r;
            r = longint'({$urandom, $urandom});
            if (i % 3 == 0) r = r >>> 21;
            else if (i % 3 == 1) r = r >>> 28;
            else r = r >>> 35;
            send(r, "R6 window mean");
            if (i % 17 == 0) idle(2);
        end
        idle(3);
        chk(longint'(avg) == last_exp, "R9 hold between results", longint'(avg), last_exp);

        // R8: full-scale run past the 16-bit quotient
        for (int i = 0; i < 1100; i++)
            send((longint'(1) <<< 43) - 1, "R8 output clamp");
        // R7: zeros evict the old window exactly
        for (int i = 0; i < WIN; i++)
            send(0, "R7 eviction");
        idle(6);
        chk(longint'(avg) == 0, "R7 drained to zero", longint'(avg), 0);
        chk(exp_q.size() == 0, "R5 every sample answered", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule